// File: doc/BRIEF.md
# Asynchronous Static RAM Request Controller

This block connects a synchronous on-chip request port to an external asynchronous byte-wide static RAM with 128K locations. A client offers a request with a valid/ready handshake: a read or a write, a 17-bit address and, for a write, a data byte. The controller converts each request into a correctly ordered set of memory strobes. Every phase lasts a fixed number of system-clock cycles. The cycle counts are set by parameters, each rounded up from the memory's nanosecond limits at the chosen clock period.

The memory is selected only when its low-active select is low and its high-active select is high. Between requests the controller parks the memory in standby by raising the low-active select.

Writes are ended by the rising edge of the write strobe. Address and data stay unchanged from before the strobe falls until one cycle after it rises. Reads hold the output enable low for the programmed access count and sample the bus on the last edge of that count. The byte is then returned with a one-cycle valid pulse.

The controller drives the data bus only while the memory's output enable is high. When a write follows a read, idle turnaround cycles are inserted before the controller turns on its drivers.

Top module: `asram_ctl`

## Requirements
- R1: While reset is asserted, both selects are inactive (low-active select high, high-active select low), write enable and output enable are high, the data drivers are off and the response valid is low.
- R2: After reset, whenever the controller is idle, reqReady is high, the low-active select is high (standby), the high-active select is high and the drivers are off.
- R3: An accepted read holds the low-active select low, output enable low and write enable high for exactly RD_CYC cycles, starting the cycle after acceptance. During that time the address is held at the request address and the drivers are off.
- R4: Read data is sampled on the clock edge that ends the access count. In the following cycle it is presented on rspRdata with rspValid high for one cycle, while output enable is already high.
- R5: An accepted write produces, in order, these phases, all with the low-active select low and output enable high: one setup cycle with write enable high, exactly WR_CYC cycles with write enable low, and one cycle with write enable high again. The controller then returns to standby.
- R6: During all write phases the memory address and the driven data equal the accepted request. They do not change while write enable is low, nor in the cycle after write enable rises, even if the request inputs change.
- R7: The data drivers are enabled only while output enable is high. Output enable and write enable are never low at the same time.
- R8: A write accepted after a read is preceded by TA_CYC turnaround cycles. In those cycles the low-active select is low, output enable and write enable are high, and the drivers are off.
- R9: A write accepted after a write, or as the first access after reset, starts its setup cycle immediately after acceptance, with no turnaround cycle.
- R10: reqReady is low in every cycle in which the memory is selected, so a request is accepted only from the idle state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Controller idle, request accepted this cycle if valid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Request address |
| reqWdata | input | DATA_W | Write data |
| rspValid | output | 1 | One-cycle strobe marking read data |
| rspRdata | output | DATA_W | Read data |
| memAddr | output | ADDR_W | Memory address bus |
| memCeN | output | 1 | Low-active memory select |
| memCe | output | 1 | High-active memory select |
| memWeN | output | 1 | Low-active write enable |
| memOeN | output | 1 | Low-active output enable |
| memDqOut | output | DATA_W | Data driven toward the memory |
| memDqOe | output | 1 | Drive enable for memDqOut |
| memDqIn | input | DATA_W | Data received from the memory |

## Verification
The hardest situation to reach is a write that directly follows a read, where the turnaround must separate the memory's drivers from the controller's. The directed sequence therefore places reads immediately before some writes and immediately before others, so both R8 and R9 are exercised. It then watches output enable and the drive enable on every cycle. Address and data hold during the write strobe are exposed by scrambling the request inputs in the cycle after acceptance. A memory model in the bench stores bytes on the rising write strobe, so later reads confirm the captured values.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_WSETUP,
    ST_WPULSE,
    ST_WEND,
    ST_RACC,
    ST_RDONE
  } state_e;

  // Registered memory-side control pins
  typedef struct packed {
    logic ceN;
    logic ce;
    logic weN;
    logic oeN;
    logic dqOe;
  } pins_t;

  // Control to datapath strobes
  typedef struct packed {
    logic load;
    logic capture;
  } strobe_t;

  localparam pins_t PINS_RESET = '{ceN: 1'b1, ce: 1'b0, weN: 1'b1, oeN: 1'b1, dqOe: 1'b0};

  function automatic pins_t pinsFor(state_e s);
    pins_t p;
    p = '{ceN: 1'b0, ce: 1'b1, weN: 1'b1, oeN: 1'b1, dqOe: 1'b0};
    case (s)
      ST_IDLE:   p.ceN = 1'b1;
      ST_TURN:   p.dqOe = 1'b0;
      ST_WSETUP: p.dqOe = 1'b1;
      ST_WPULSE: begin p.weN = 1'b0; p.dqOe = 1'b1; end
      ST_WEND:   p.dqOe = 1'b1;
      ST_RACC:   p.oeN = 1'b0;
      ST_RDONE:  p.oeN = 1'b1;
      default:   p.ceN = 1'b1;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/asram_ctl_fsm.sv
module asram_ctl_fsm
  import asram_pkg::*;
#(
  parameter int WR_CYC = 2,
  parameter int RD_CYC = 3,
  parameter int TA_CYC = 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output strobe_t stb,
  output pins_t   pins,
  output logic    rspValid
);

  localparam int MAX_A = (WR_CYC > RD_CYC) ? WR_CYC : RD_CYC;
  localparam int MAX_C = (MAX_A > TA_CYC) ? MAX_A : TA_CYC;
  localparam int CNT_W = $clog2(MAX_C + 1);

  state_e stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD;
  logic lastReadQ, lastReadD;
  logic accept;

  assign reqReady = (stateQ == ST_IDLE);
  assign accept   = reqValid && reqReady;

  always_comb begin
    stateD      = stateQ;
    cntD        = cntQ;
    lastReadD   = lastReadQ;
    stb.load    = 1'b0;
    stb.capture = 1'b0;
    case (stateQ)
      ST_IDLE: begin
        if (accept) begin
          stb.load = 1'b1;
          if (reqWrite) begin
            lastReadD = 1'b0;
            if (lastReadQ) begin
              stateD = ST_TURN;
              cntD   = CNT_W'(TA_CYC - 1);
            end else begin
              stateD = ST_WSETUP;
            end
          end else begin
            lastReadD = 1'b1;
            stateD    = ST_RACC;
            cntD      = CNT_W'(RD_CYC - 1);
          end
        end
      end
      ST_TURN: begin
        if (cntQ == '0) stateD = ST_WSETUP;
        else            cntD   = cntQ - 1'b1;
      end
      ST_WSETUP: begin
        stateD = ST_WPULSE;
        cntD   = CNT_W'(WR_CYC - 1);
      end
      ST_WPULSE: begin
        if (cntQ == '0) stateD = ST_WEND;
        else            cntD   = cntQ - 1'b1;
      end
      ST_WEND: stateD = ST_IDLE;
      ST_RACC: begin
        if (cntQ == '0) begin
          stateD      = ST_RDONE;
          stb.capture = 1'b1;
        end else begin
          cntD = cntQ - 1'b1;
        end
      end
      ST_RDONE: stateD = ST_IDLE;
      default:  stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      cntQ      <= '0;
      lastReadQ <= 1'b0;
      pins      <= PINS_RESET;
      rspValid  <= 1'b0;
    end else begin
      stateQ    <= stateD;
      cntQ      <= cntD;
      lastReadQ <= lastReadD;
      pins      <= pinsFor(stateD);
      rspValid  <= stb.capture;
    end
  end

endmodule

// File: rtl/asram_ctl_dp.sv
module asram_ctl_dp
  import asram_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic [DATA_W-1:0] rspRdata
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr  <= '0;
      memDqOut <= '0;
      rspRdata <= '0;
    end else begin
      if (stb.load) begin
        memAddr  <= reqAddr;
        memDqOut <= reqWdata;
      end
      if (stb.capture) rspRdata <= memDqIn;
    end
  end

endmodule

// File: rtl/asram_ctl.sv
module asram_ctl
  import asram_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int WR_CYC = 2,
  parameter int RD_CYC = 3,
  parameter int TA_CYC = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memCe,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  strobe_t stb;
  pins_t   pins;

  asram_ctl_fsm #(.WR_CYC(WR_CYC), .RD_CYC(RD_CYC), .TA_CYC(TA_CYC)) u_fsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .stb(stb), .pins(pins), .rspValid(rspValid)
  );

  asram_ctl_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .memDqIn(memDqIn), .memAddr(memAddr), .memDqOut(memDqOut), .rspRdata(rspRdata)
  );

  assign memCeN  = pins.ceN;
  assign memCe   = pins.ce;
  assign memWeN  = pins.weN;
  assign memOeN  = pins.oeN;
  assign memDqOe = pins.dqOe;

endmodule

// File: rtl/asram_ctl_chk.sv
module asram_ctl_chk #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rspValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCeN,
  input logic              memCe,
  input logic              memWeN,
  input logic              memOeN,
  input logic [DATA_W-1:0] memDqOut,
  input logic              memDqOe
);

  p_standby_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memCeN && !memDqOe));

  p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && memCe) |-> !reqReady);

  p_read_strobes_r3: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> (!memCeN && memWeN && !memDqOe));

  p_drive_oe_high_r7: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> memOeN);

  p_we_selected_r5: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (!memCeN && memCe && memDqOe));

  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |=> ($stable(memAddr) && $stable(memDqOut) && memDqOe));

  p_rsp_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  p_rsp_oe_released_r4: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> memOeN);

  p_turn_before_drive_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memDqOe) |-> $past(memOeN));

endmodule

bind asram_ctl asram_ctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .rspValid(rspValid),
  .memAddr(memAddr), .memCeN(memCeN), .memCe(memCe), .memWeN(memWeN),
  .memOeN(memOeN), .memDqOut(memDqOut), .memDqOe(memDqOe)
);

// File: tb/asram_ctl_test.sv
`timescale 1ns/1ps
module asram_ctl_test;

  localparam int ADDR_W = 17;
  localparam int DATA_W = 8;
  localparam int WR_CYC = 2;
  localparam int RD_CYC = 3;
  localparam int TA_CYC = 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic reqReady, rspValid;
  logic [DATA_W-1:0] rspRdata;
  logic [ADDR_W-1:0] memAddr;
  logic memCeN, memCe, memWeN, memOeN, memDqOe;
  logic [DATA_W-1:0] memDqOut;
  logic [DATA_W-1:0] memDqIn = '0;

  int checks = 0;
  int fails = 0;
  int clash = 0;
  logic [DATA_W-1:0] memArr [int];
  logic [DATA_W-1:0] shadow [int];

  always #2 clk = ~clk;

  asram_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_CYC(WR_CYC),
              .RD_CYC(RD_CYC), .TA_CYC(TA_CYC)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata), .memAddr(memAddr),
    .memCeN(memCeN), .memCe(memCe), .memWeN(memWeN), .memOeN(memOeN),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  // Memory model: stores on rising write strobe, drives after OE falls
  always @(posedge memWeN)
    if (memCeN === 1'b0 && memCe === 1'b1) memArr[int'(memAddr)] = memDqOut;

  always @(negedge clk) begin
    if (memCeN === 1'b0 && memCe === 1'b1 && memWeN === 1'b1 && memOeN === 1'b0)
      memDqIn <= memArr.exists(int'(memAddr)) ? memArr[int'(memAddr)] : 8'hA5;
    else
      memDqIn <= 8'h00;
    if (rstN && ((memDqOe && !memOeN) || (!memWeN && !memOeN))) clash++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {ceN, weN, oeN, dqOe}
  task automatic chkPins(input string tag, input logic [3:0] exp);
    chk({memCeN, memWeN, memOeN, memDqOe} === exp, tag,
        int'({memCeN, memWeN, memOeN, memDqOe}), int'(exp));
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chkPins("R1 reset pins", 4'b1110);
    chk(memCe === 1'b0, "R1 reset high-active select", int'(memCe), 0);
    chk(rspValid === 1'b0, "R1 reset rspValid", int'(rspValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    chkPins("R2 idle pins", 4'b1110);
    chk(memCe === 1'b1 && reqReady === 1'b1, "R2 idle ready/select",
        int'({memCe, reqReady}), 3);
  endtask

  task automatic doWrite(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                         input bit expTurn);
    @(negedge clk);
    chk(reqReady === 1'b1, "R10 ready before write", int'(reqReady), 1);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0; reqAddr = ~a; reqWdata = ~d;
    if (expTurn) begin
      for (int i = 0; i < TA_CYC; i++) begin
        chkPins("R8 turnaround pins", 4'b0110);
        @(negedge clk);
      end
    end
    chkPins(expTurn ? "R8 setup after turnaround" : "R9 setup without turnaround", 4'b0111);
    chk(memAddr === a && memDqOut === d, "R6 setup addr/data",
        int'({memAddr, memDqOut}), int'({a, d}));
    @(negedge clk);
    for (int i = 0; i < WR_CYC; i++) begin
      chkPins("R5 write pulse", 4'b0011);
      chk(memAddr === a && memDqOut === d, "R6 pulse addr/data",
          int'({memAddr, memDqOut}), int'({a, d}));
      chk(reqReady === 1'b0, "R10 busy during write", int'(reqReady), 0);
      @(negedge clk);
    end
    chkPins("R5 write end", 4'b0111);
    chk(memAddr === a && memDqOut === d, "R6 hold addr/data",
        int'({memAddr, memDqOut}), int'({a, d}));
    @(negedge clk);
    chkPins("R5 back to standby", 4'b1110);
    chk(reqReady === 1'b1, "R2 ready after write", int'(reqReady), 1);
    shadow[int'(a)] = d;
  endtask

  task automatic doRead(input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] e;
    e = shadow.exists(int'(a)) ? shadow[int'(a)] : 8'hA5;
    @(negedge clk);
    chk(reqReady === 1'b1, "R10 ready before read", int'(reqReady), 1);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0; reqAddr = ~a;
    for (int i = 0; i < RD_CYC; i++) begin
      chkPins("R3 read access pins", 4'b0100);
      chk(memAddr === a, "R3 read address", int'(memAddr), int'(a));
      chk(rspValid === 1'b0 && reqReady === 1'b0, "R10 busy during read",
          int'({rspValid, reqReady}), 0);
      @(negedge clk);
    end
    chk(rspValid === 1'b1, "R4 rspValid", int'(rspValid), 1);
    chk(rspRdata === e, "R4 read data", int'(rspRdata), int'(e));
    chk(memOeN === 1'b1, "R4 OE released", int'(memOeN), 1);
    @(negedge clk);
    chk(rspValid === 1'b0, "R4 rspValid single pulse", int'(rspValid), 0);
    chkPins("R2 standby after read", 4'b1110);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    testReset();
    doWrite(17'h00000, 8'h3C, 1'b0);   // first write after reset, R9
    doWrite(17'h1FFFF, 8'hC3, 1'b0);   // write after write, R9
    doRead(17'h00000);
    doRead(17'h1FFFF);                 // back-to-back reads
    doWrite(17'h12345, 8'hA7, 1'b1);   // write after read, R8
    doRead(17'h12345);
    doWrite(17'h00001, 8'h5E, 1'b1);   // R8 again
    doWrite(17'h00002, 8'h81, 1'b0);   // R9
    doRead(17'h00001);
    doRead(17'h00002);
    chk(clash == 0, "R7 drive/OE/WE overlap count", clash, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule